// File: doc/BRIEF.md
# Key-Table Context Save Sequencer

This block walks the saved state of a crypto engine and presents it as a fixed, ordered stream of 128-bit block requests. Each request names where the block comes from (a source code), which key it belongs to, and which 128-bit quarter of that key, or word-quad, it is. An external sink encrypts and writes each block. Restore logic relies on the same order after a power-down, so the sequence never varies for a given layout.

Software pulses a start together with a layout choice. The base layout holds the random block, the sticky words, the symmetric key table, the RSA key area and a closing known-pattern block. The extended layout adds the public-key accelerator's sticky block and key area before the pattern block. The sequencer keeps a progress counter of blocks the sink has acknowledged. It refuses to start unless that counter is zero. At the end it compares the counter with the layout size.

Top module: `ctxsave_seq`

## Requirements
- R1: After reset, busy, the done interrupt, all three error flags, the request valid and the progress counter are all zero.
- R2: Every sequence opens with one source-0 block (random data). Next come source-1 blocks with word-quad 0 and then 1 (sticky words). Then come 16 symmetric slots with source code 2 and key = slot. Each slot emits word-quads 0 and 1 (key halves), 2 (original IV) and 3 (updated IV). The last block is always source 6 (known pattern).
- R3: The RSA area follows the symmetric table with source code 3. There are 2 slots. For slot s, 16 word-quads (0..15) are sent with key index 2s+1 (modulus), then 16 more with key index 2s (exponent).
- R4: In the extended layout, one source-4 block (accelerator sticky, key 0, word-quad 0) follows the RSA area. Then come 512 source-5 blocks for 4 slots × 128 quads, with key = slot and word-quad = slot*128+quad, all before the pattern block.
- R5: While the source is 6, the pattern output carries byte value i in bits [8i+7:8i] for i = 0..15. It is zero for every other source.
- R6: The layout input is sampled only when a start is accepted. Changing it mid-sequence does not alter the stream or its length.
- R7: The counter rises by one per successfully acknowledged block. It ends at 132 (base) or 645 (extended). A length flag is raised at the end only if the counter differs from the layout size.
- R8: A start while idle with a non-zero counter is refused. It sets the sticky reject flag, emits no request and leaves the counter and busy unchanged.
- R9: A request accepted only when valid and ready are high in the same cycle. While it waits for ready, its valid, source, key and word-quad stay unchanged. No new request is raised until the sink acknowledges the previous one.
- R10: An acknowledge with the error bit set aborts the sequence. It sets the sticky sink-error flag, does not count the failed block, returns to idle and raises no done interrupt.
- R11: Busy is high from an accepted start until the final acknowledge. No request is raised while idle. The done interrupt is set at the final acknowledge and cleared by a one-cycle clear pulse.
- R12: The clear input, honoured only while idle, zeroes the counter and the reject, sink-error and length flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| layout_ext_i | input | 1 | 1 selects the extended layout, sampled at start |
| clr_i | input | 1 | Clears counter and error flags while idle |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the done interrupt |
| req_valid_o | output | 1 | Block request pending |
| req_ready_i | input | 1 | Sink takes the request |
| req_src_o | output | 3 | Source code of the block |
| req_key_o | output | KEY_W (4) | Key or slot index |
| req_quad_o | output | OQ_W (9) | Word-quad index |
| req_pattern_o | output | 128 | Known-pattern data for source 6 |
| ack_i | input | 1 | Sink finished the accepted block |
| ack_err_i | input | 1 | Sink failed the block (qualified by ack_i) |
| count_o | output | CNT_W (12) | Progress counter |
| busy_o | output | 1 | Sequence in progress |
| irq_done_o | output | 1 | Sequence completed interrupt |
| err_reject_o | output | 1 | Start refused, sticky |
| err_sink_o | output | 1 | Sink error abort, sticky |
| err_length_o | output | 1 | Final count mismatch, sticky |

## Verification
The bench builds the sequencer with its default sizes: 16 symmetric slots, 2 RSA slots of 16 quads, and an accelerator area of 4 × 128 quads. With the accelerator option present, the complete 645-block extended stream and the 132-block base stream can be compared block by block. The same build reaches the modulus-before-exponent index reversal and the slot*128+quad linear index at its largest value. The widths chosen by default also let a counter value of 645 show the final length, and a sink stall pattern exercises request holding on every third cycle.

// File: rtl/ctxsave_pkg.sv
package ctxsave_pkg;

   typedef enum logic [2:0] {
      SRC_RAND       = 3'd0,
      SRC_STICKY     = 3'd1,
      SRC_SYMKEY     = 3'd2,
      SRC_RSAKEY     = 3'd3,
      SRC_ACC_STICKY = 3'd4,
      SRC_ACC_KEY    = 3'd5,
      SRC_PATTERN    = 3'd6
   } src_e;

   typedef enum logic [2:0] {
      PH_RAND,
      PH_STICKY,
      PH_SYM,
      PH_RSA,
      PH_ACC_STK,
      PH_ACC_KEY,
      PH_PATTERN
   } phase_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT
   } state_e;

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   // byte i of the closing block holds the value i
   function automatic logic [127:0] known_pattern();
      logic [127:0] p;
      for (int i = 0; i < 16; i++) begin
         p[8*i +: 8] = 8'(i);
      end
      return p;
   endfunction

endpackage

// File: rtl/ctxsave_walker.sv
module ctxsave_walker
   import ctxsave_pkg::*;
#(
   parameter int STICKY_BLKS = 2,
   parameter int SYM_SLOTS   = 16,
   parameter int RSA_SLOTS   = 2,
   parameter int RSA_QUADS   = 16,
   parameter int ACC_SLOTS   = 4,
   parameter int ACC_QUADS   = 128,
   parameter int KEY_W       = 4,
   parameter int OQ_W        = 9,
   parameter int SL_W        = 4,
   parameter int QD_W        = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             init_i,
   input  logic             adv_i,
   input  logic             ext_i,
   output src_e             src_o,
   output logic [KEY_W-1:0] key_o,
   output logic [OQ_W-1:0]  quad_o,
   output logic             last_o
);

   localparam int SYM_PARTS = 4;

   phase_e          ph_q;
   logic [SL_W-1:0] slot_q;
   logic [1:0]      part_q;
   logic [QD_W-1:0] quad_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_RAND;
         slot_q <= '0;
         part_q <= '0;
         quad_q <= '0;
      end else if (init_i) begin
         ph_q   <= PH_RAND;
         slot_q <= '0;
         part_q <= '0;
         quad_q <= '0;
      end else if (adv_i) begin
         case (ph_q)
            PH_RAND: begin
               ph_q   <= PH_STICKY;
               quad_q <= '0;
            end
            PH_STICKY: begin
               if (quad_q == QD_W'(STICKY_BLKS - 1)) begin
                  ph_q   <= PH_SYM;
                  quad_q <= '0;
                  slot_q <= '0;
                  part_q <= '0;
               end else begin
                  quad_q <= quad_q + 1'b1;
               end
            end
            PH_SYM: begin
               if (part_q == 2'(SYM_PARTS - 1)) begin
                  part_q <= '0;
                  if (slot_q == SL_W'(SYM_SLOTS - 1)) begin
                     ph_q   <= PH_RSA;
                     slot_q <= '0;
                     quad_q <= '0;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                  end
               end else begin
                  part_q <= part_q + 1'b1;
               end
            end
            PH_RSA: begin
               if (quad_q == QD_W'(RSA_QUADS - 1)) begin
                  quad_q <= '0;
                  if (part_q[0]) begin
                     part_q <= '0;
                     if (slot_q == SL_W'(RSA_SLOTS - 1)) begin
                        slot_q <= '0;
                        ph_q   <= ext_i ? PH_ACC_STK : PH_PATTERN;
                     end else begin
                        slot_q <= slot_q + 1'b1;
                     end
                  end else begin
                     part_q <= 2'd1;
                  end
               end else begin
                  quad_q <= quad_q + 1'b1;
               end
            end
            PH_ACC_STK: begin
               ph_q   <= PH_ACC_KEY;
               slot_q <= '0;
               quad_q <= '0;
            end
            PH_ACC_KEY: begin
               if (quad_q == QD_W'(ACC_QUADS - 1)) begin
                  quad_q <= '0;
                  if (slot_q == SL_W'(ACC_SLOTS - 1)) begin
                     slot_q <= '0;
                     ph_q   <= PH_PATTERN;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                  end
               end else begin
                  quad_q <= quad_q + 1'b1;
               end
            end
            default: ph_q <= PH_PATTERN;
         endcase
      end
   end

   always_comb begin
      src_o  = SRC_RAND;
      key_o  = '0;
      quad_o = '0;
      case (ph_q)
         PH_STICKY: begin
            src_o  = SRC_STICKY;
            quad_o = OQ_W'(quad_q);
         end
         PH_SYM: begin
            src_o  = SRC_SYMKEY;
            key_o  = KEY_W'(slot_q);
            quad_o = OQ_W'(part_q);
         end
         PH_RSA: begin
            // modulus (odd index) goes out before exponent (even index)
            src_o  = SRC_RSAKEY;
            key_o  = KEY_W'({slot_q, ~part_q[0]});
            quad_o = OQ_W'(quad_q);
         end
         PH_ACC_STK: src_o = SRC_ACC_STICKY;
         PH_ACC_KEY: begin
            src_o  = SRC_ACC_KEY;
            key_o  = KEY_W'(slot_q);
            quad_o = OQ_W'(slot_q) * OQ_W'(ACC_QUADS) + OQ_W'(quad_q);
         end
         PH_PATTERN: src_o = SRC_PATTERN;
         default: src_o = SRC_RAND;
      endcase
   end

   assign last_o = (ph_q == PH_PATTERN);

endmodule

// File: rtl/ctxsave_progress.sv
module ctxsave_progress #(
   parameter int CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic             end_i,
   input  logic [CNT_W-1:0] total_i,
   output logic [CNT_W-1:0] count_o,
   output logic             len_err_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             len_q;

   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         len_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         len_q <= 1'b0;
      end else if (inc_i) begin
         cnt_q <= cnt_nxt;
         if (end_i && (cnt_nxt != total_i)) begin
            len_q <= 1'b1;
         end
      end
   end

   assign count_o   = cnt_q;
   assign len_err_o = len_q;

endmodule

// File: rtl/ctxsave_seq.sv
module ctxsave_seq
   import ctxsave_pkg::*;
#(
   parameter int  STICKY_BLKS = 2,
   parameter int  SYM_SLOTS   = 16,
   parameter int  RSA_SLOTS   = 2,
   parameter int  RSA_QUADS   = 16,
   parameter int  ACC_SLOTS   = 4,
   parameter int  ACC_QUADS   = 128,
   parameter bit  HAS_ACCEL   = 1'b1,
   parameter int  CNT_W       = 12,
   localparam int TOTAL_BASE  = 1 + STICKY_BLKS + SYM_SLOTS * 4 + RSA_SLOTS * 2 * RSA_QUADS + 1,
   localparam int TOTAL_EXT   = TOTAL_BASE + 1 + ACC_SLOTS * ACC_QUADS,
   localparam int KEY_W       = $clog2(imax(imax(SYM_SLOTS, 2 * RSA_SLOTS), ACC_SLOTS)),
   localparam int OQ_W        = $clog2(imax(imax(ACC_SLOTS * ACC_QUADS, RSA_QUADS), imax(STICKY_BLKS, 4)))
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             layout_ext_i,
   input  logic             clr_i,
   input  logic             irq_clr_i,
   output logic             req_valid_o,
   input  logic             req_ready_i,
   output logic [2:0]       req_src_o,
   output logic [KEY_W-1:0] req_key_o,
   output logic [OQ_W-1:0]  req_quad_o,
   output logic [127:0]     req_pattern_o,
   input  logic             ack_i,
   input  logic             ack_err_i,
   output logic [CNT_W-1:0] count_o,
   output logic             busy_o,
   output logic             irq_done_o,
   output logic             err_reject_o,
   output logic             err_sink_o,
   output logic             err_length_o
);

   localparam int SL_W = imax(1, $clog2(imax(imax(SYM_SLOTS, RSA_SLOTS), ACC_SLOTS)));
   localparam int QD_W = imax(1, $clog2(imax(imax(RSA_QUADS, ACC_QUADS), STICKY_BLKS)));

   // elaboration-time parameter checks
   if ((2 ** CNT_W) <= TOTAL_EXT) begin : g_bad_cnt
      $error("CNT_W too narrow for the extended layout size");
   end
   if (SYM_SLOTS < 1 || RSA_SLOTS < 1 || ACC_SLOTS < 1) begin : g_bad_slots
      $error("every key area needs at least one slot");
   end
   if (RSA_QUADS < 1 || ACC_QUADS < 1 || STICKY_BLKS < 1) begin : g_bad_quads
      $error("quad and sticky counts must be positive");
   end

   // layout variant: without the accelerator the extended request is ignored
   logic ext_sel;
   if (HAS_ACCEL) begin : g_accel
      assign ext_sel = layout_ext_i;
   end else begin : g_no_accel
      assign ext_sel = 1'b0;
   end

   state_e st_q;
   logic   ext_q;
   logic   irq_q;
   logic   rej_q;
   logic   snk_q;

   src_e             w_src;
   logic [KEY_W-1:0] w_key;
   logic [OQ_W-1:0]  w_quad;
   logic             w_last;
   logic [CNT_W-1:0] cnt;

   logic start_ok;
   logic start_bad;
   logic ack_ok;
   logic ack_bad;
   logic gen_init;
   logic gen_adv;
   logic cnt_clr;
   logic [CNT_W-1:0] total;

   assign start_ok  = (st_q == ST_IDLE) && start_i && (cnt == '0);
   assign start_bad = (st_q == ST_IDLE) && start_i && (cnt != '0);
   assign ack_ok    = (st_q == ST_WAIT) && ack_i && !ack_err_i;
   assign ack_bad   = (st_q == ST_WAIT) && ack_i && ack_err_i;
   assign gen_init  = start_ok;
   assign gen_adv   = ack_ok && !w_last;
   assign cnt_clr   = (st_q == ST_IDLE) && clr_i;
   assign total     = ext_q ? CNT_W'(TOTAL_EXT) : CNT_W'(TOTAL_BASE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         ext_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_ok) begin
                  st_q  <= ST_ISSUE;
                  ext_q <= ext_sel;
               end
            end
            ST_ISSUE: begin
               if (req_ready_i) begin
                  st_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (ack_bad) begin
                  st_q <= ST_IDLE;
               end else if (ack_ok) begin
                  st_q <= w_last ? ST_IDLE : ST_ISSUE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
         rej_q <= 1'b0;
         snk_q <= 1'b0;
      end else begin
         if (ack_ok && w_last) begin
            irq_q <= 1'b1;
         end else if (irq_clr_i) begin
            irq_q <= 1'b0;
         end
         if (cnt_clr) begin
            rej_q <= 1'b0;
            snk_q <= 1'b0;
         end else begin
            if (start_bad) begin
               rej_q <= 1'b1;
            end
            if (ack_bad) begin
               snk_q <= 1'b1;
            end
         end
      end
   end

   ctxsave_walker #(
      .STICKY_BLKS (STICKY_BLKS),
      .SYM_SLOTS   (SYM_SLOTS),
      .RSA_SLOTS   (RSA_SLOTS),
      .RSA_QUADS   (RSA_QUADS),
      .ACC_SLOTS   (ACC_SLOTS),
      .ACC_QUADS   (ACC_QUADS),
      .KEY_W       (KEY_W),
      .OQ_W        (OQ_W),
      .SL_W        (SL_W),
      .QD_W        (QD_W)
   ) walk_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .init_i (gen_init),
      .adv_i  (gen_adv),
      .ext_i  (ext_q),
      .src_o  (w_src),
      .key_o  (w_key),
      .quad_o (w_quad),
      .last_o (w_last)
   );

   ctxsave_progress #(
      .CNT_W (CNT_W)
   ) prog_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (cnt_clr),
      .inc_i     (ack_ok),
      .end_i     (w_last),
      .total_i   (total),
      .count_o   (cnt),
      .len_err_o (err_length_o)
   );

   assign req_valid_o   = (st_q == ST_ISSUE);
   assign req_src_o     = w_src;
   assign req_key_o     = w_key;
   assign req_quad_o    = w_quad;
   assign req_pattern_o = (w_src == SRC_PATTERN) ? known_pattern() : '0;
   assign count_o       = cnt;
   assign busy_o        = (st_q != ST_IDLE);
   assign irq_done_o    = irq_q;
   assign err_reject_o  = rej_q;
   assign err_sink_o    = snk_q;

endmodule

// File: rtl/ctxsave_chk.sv
module ctxsave_chk #(
   parameter int KEY_W = 4,
   parameter int OQ_W  = 9,
   parameter int CNT_W = 12,
   parameter int TOTAL = 645
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             req_valid_o,
   input logic             req_ready_i,
   input logic [2:0]       req_src_o,
   input logic [KEY_W-1:0] req_key_o,
   input logic [OQ_W-1:0]  req_quad_o,
   input logic             ack_i,
   input logic             ack_err_i,
   input logic [CNT_W-1:0] count_o,
   input logic             busy_o,
   input logic             irq_done_o,
   input logic             err_reject_o,
   input logic             err_sink_o
);

   logic pv_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pv_q <= 1'b0;
      else         pv_q <= 1'b1;
   end

   AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
      req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_src_o) && $stable(req_key_o) && $stable(req_quad_o)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !req_valid_o); // R11

   AST_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
      start_i && !busy_o && (count_o != '0) |=> !busy_o && err_reject_o); // R8

   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
      (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1) || (count_o == '0)); // R7

   AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o <= CNT_W'(TOTAL)); // R7

   AST_FAIL_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
      busy_o && !req_valid_o && ack_i && ack_err_i |=> !busy_o && err_sink_o && $stable(count_o) && !$rose(irq_done_o)); // R10

   AST_IRQ_END: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
      $rose(irq_done_o) |-> $fell(busy_o)); // R11

   AST_FIRST_RAND: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
      $rose(busy_o) |-> req_valid_o && (req_src_o == 3'd0)); // R2

endmodule

bind ctxsave_seq ctxsave_chk #(
   .KEY_W (KEY_W),
   .OQ_W  (OQ_W),
   .CNT_W (CNT_W),
   .TOTAL (TOTAL_EXT)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .start_i      (start_i),
   .req_valid_o  (req_valid_o),
   .req_ready_i  (req_ready_i),
   .req_src_o    (req_src_o),
   .req_key_o    (req_key_o),
   .req_quad_o   (req_quad_o),
   .ack_i        (ack_i),
   .ack_err_i    (ack_err_i),
   .count_o      (count_o),
   .busy_o       (busy_o),
   .irq_done_o   (irq_done_o),
   .err_reject_o (err_reject_o),
   .err_sink_o   (err_sink_o)
);

// File: tb/ctxsave_seq_tb_top.sv
module ctxsave_seq_tb_top;

   localparam int KEY_W = 4;
   localparam int OQ_W  = 9;
   localparam int CNT_W = 12;
   localparam logic [127:0] PAT = 128'h0f0e0d0c0b0a09080706050403020100;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic             start_i = 1'b0;
   logic             layout_ext_i = 1'b0;
   logic             clr_i = 1'b0;
   logic             irq_clr_i = 1'b0;
   logic             req_valid_o;
   logic             req_ready_i = 1'b1;
   logic [2:0]       req_src_o;
   logic [KEY_W-1:0] req_key_o;
   logic [OQ_W-1:0]  req_quad_o;
   logic [127:0]     req_pattern_o;
   logic             ack_i = 1'b0;
   logic             ack_err_i = 1'b0;
   logic [CNT_W-1:0] count_o;
   logic             busy_o;
   logic             irq_done_o;
   logic             err_reject_o;
   logic             err_sink_o;
   logic             err_length_o;

   always #4 clk_i = ~clk_i;  // 125 MHz

   ctxsave_seq dut_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .start_i       (start_i),
      .layout_ext_i  (layout_ext_i),
      .clr_i         (clr_i),
      .irq_clr_i     (irq_clr_i),
      .req_valid_o   (req_valid_o),
      .req_ready_i   (req_ready_i),
      .req_src_o     (req_src_o),
      .req_key_o     (req_key_o),
      .req_quad_o    (req_quad_o),
      .req_pattern_o (req_pattern_o),
      .ack_i         (ack_i),
      .ack_err_i     (ack_err_i),
      .count_o       (count_o),
      .busy_o        (busy_o),
      .irq_done_o    (irq_done_o),
      .err_reject_o  (err_reject_o),
      .err_sink_o    (err_sink_o),
      .err_length_o  (err_length_o)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard: {src[2:0], key[3:0], quad[8:0]}
   logic [15:0] expq[$];
   int  acc_n  = 0;
   int  err_at = -1;
   bit  stall  = 1'b0;
   bit  pend   = 1'b0;
   bit  pend_err = 1'b0;
   bit  hold_chk = 1'b0;
   logic [15:0] held;
   int  cyc = 0;

   function automatic logic [15:0] item(int src, int key, int quad);
      return {3'(src), 4'(key), 9'(quad)};
   endfunction

   task automatic push_expected(input bit ext);
      expq.push_back(item(0, 0, 0));
      for (int q = 0; q < 2; q++) expq.push_back(item(1, 0, q));
      for (int s = 0; s < 16; s++)
         for (int p = 0; p < 4; p++) expq.push_back(item(2, s, p));
      for (int s = 0; s < 2; s++)
         for (int h = 0; h < 2; h++)
            for (int q = 0; q < 16; q++) expq.push_back(item(3, 2*s + ((h == 0) ? 1 : 0), q));
      if (ext) begin
         expq.push_back(item(4, 0, 0));
         for (int s = 0; s < 4; s++)
            for (int q = 0; q < 128; q++) expq.push_back(item(5, s, s*128 + q));
      end
      expq.push_back(item(6, 0, 0));
   endtask

   // monitor / sink model
   initial begin
      logic [15:0] cur;
      logic [15:0] e;
      forever begin
         @(negedge clk_i);
         cyc++;
         ack_i = 1'b0;
         ack_err_i = 1'b0;
         if (pend) begin
            ack_i = 1'b1;
            ack_err_i = pend_err;
            pend = 1'b0;
         end
         cur = {req_src_o, req_key_o, req_quad_o};
         if (hold_chk) begin
            check(req_valid_o && (cur == held), "R9 held request", 32'(cur), 32'(held));
            hold_chk = 1'b0;
         end
         req_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
         if (req_valid_o) begin
            if (req_ready_i) begin
               if (expq.size() == 0) begin
                  check(1'b0, "R8 unexpected request", 32'(cur), 32'hffff);
               end else begin
                  e = expq.pop_front();
                  if (e[15:13] == 3'd3)
                     check(cur == e, "R3 rsa block", 32'(cur), 32'(e));
                  else if (e[15:13] == 3'd4 || e[15:13] == 3'd5)
                     check(cur == e, "R4 accel block", 32'(cur), 32'(e));
                  else
                     check(cur == e, "R2 block order", 32'(cur), 32'(e));
                  if (e[15:13] == 3'd6)
                     check(req_pattern_o == PAT, "R5 pattern", req_pattern_o[31:0], PAT[31:0]);
                  else
                     check(req_pattern_o == '0, "R5 pattern zero", req_pattern_o[31:0], 32'h0);
               end
               pend = 1'b1;
               pend_err = (acc_n == err_at);
               acc_n++;
            end else begin
               hold_chk = 1'b1;
               held = cur;
            end
         end
      end
   end

   task automatic run_seq(input bit ext, input bit flip);
      int n;
      push_expected(ext);
      acc_n = 0;
      @(negedge clk_i);
      layout_ext_i = ext;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R11 busy after start", 32'(busy_o), 32'h1);
      n = 0;
      while (busy_o) begin
         @(negedge clk_i);
         n++;
         if (flip && n == 20) layout_ext_i = ~ext;
      end
      layout_ext_i = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk_i);
      clr_i = 1'b1;
      @(negedge clk_i);
      clr_i = 1'b0;
   endtask

   task automatic pulse_irq_clr();
      @(negedge clk_i);
      irq_clr_i = 1'b1;
      @(negedge clk_i);
      irq_clr_i = 1'b0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      // R1 reset state
      check({busy_o, irq_done_o, err_reject_o, err_sink_o, err_length_o, req_valid_o} == 6'b0,
            "R1 reset flags", 32'({busy_o, irq_done_o, err_reject_o, err_sink_o, err_length_o, req_valid_o}), 32'h0);
      check(count_o == '0, "R1 reset count", 32'(count_o), 32'h0);

      // base layout with sink stalls (R2, R3, R5, R9)
      stall = 1'b1;
      run_seq(1'b0, 1'b0);
      stall = 1'b0;
      check(count_o == 12'd132, "R7 base count", 32'(count_o), 32'd132);
      check(err_length_o == 1'b0, "R7 length flag", 32'(err_length_o), 32'h0);
      check(irq_done_o == 1'b1, "R11 irq set", 32'(irq_done_o), 32'h1);
      check(expq.size() == 0, "R2 stream complete", 32'(expq.size()), 32'h0);

      // refused start with non-zero counter (R8)
      @(negedge clk_i);
      layout_ext_i = 1'b1;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      layout_ext_i = 1'b0;
      repeat (4) @(negedge clk_i);
      check(busy_o == 1'b0, "R8 busy stays low", 32'(busy_o), 32'h0);
      check(err_reject_o == 1'b1, "R8 reject flag", 32'(err_reject_o), 32'h1);
      check(count_o == 12'd132, "R8 count kept", 32'(count_o), 32'd132);

      // interrupt clear (R11)
      pulse_irq_clr();
      check(irq_done_o == 1'b0, "R11 irq cleared", 32'(irq_done_o), 32'h0);

      // clear (R12)
      pulse_clr();
      check(count_o == '0, "R12 count cleared", 32'(count_o), 32'h0);
      check(err_reject_o == 1'b0, "R12 reject cleared", 32'(err_reject_o), 32'h0);

      // extended layout (R4, R7)
      run_seq(1'b1, 1'b0);
      check(count_o == 12'd645, "R7 extended count", 32'(count_o), 32'd645);
      check(expq.size() == 0, "R4 stream complete", 32'(expq.size()), 32'h0);

      // layout change mid-run ignored (R6)
      pulse_clr();
      pulse_irq_clr();
      run_seq(1'b0, 1'b1);
      check(count_o == 12'd132, "R6 layout held", 32'(count_o), 32'd132);
      check(expq.size() == 0, "R6 stream length", 32'(expq.size()), 32'h0);

      // sink error abort on the sixth block (R10)
      pulse_clr();
      pulse_irq_clr();
      err_at = 5;
      run_seq(1'b0, 1'b0);
      err_at = -1;
      repeat (2) @(negedge clk_i);
      check(count_o == 12'd5, "R10 count not advanced", 32'(count_o), 32'd5);
      check(err_sink_o == 1'b1, "R10 sink flag", 32'(err_sink_o), 32'h1);
      check(busy_o == 1'b0, "R10 idle", 32'(busy_o), 32'h0);
      check(irq_done_o == 1'b0, "R10 no irq", 32'(irq_done_o), 32'h0);
      check(req_valid_o == 1'b0, "R10 no request", 32'(req_valid_o), 32'h0);
      expq.delete();

      finish_run();
   end

endmodule